// File: doc/BRIEF.md
# Pin Interrupt Detector Bank

This block holds the interrupt logic for a small bank of general-purpose input pins inside a pin controller. Each pin is brought through a two-stage synchronizer. It can watch for a level, a rising edge, a falling edge or both edges, depending on its configuration register. A detected event is latched into a per-pin status bit. That bit stays set until software acknowledges it through a register write, or until the pin is unmasked.

Each pin carries a 3-bit routing field. The block produces one interrupt line per possible destination. A line is asserted when any enabled pin routed to it has its status set. A parameter builds the detector in one of two variants. The wide variant has a native both-edge mode. The narrow variant has a single detect bit, so software must flip the polarity after each event to follow both edges.

Per pin, the detector is a three-state machine:
- ST_OFF: raw detection is disabled and the status reads 0.
- ST_QUIET: watching, status clear.
- ST_CAUGHT: status set.

The transitions are:
- OFF to QUIET when raw detection is enabled.
- QUIET to CAUGHT on a hit.
- CAUGHT to QUIET on an acknowledge or an unmask with no hit in the same cycle.
- CAUGHT to CAUGHT on a hit. This covers a hit in the same cycle as a clear.
- QUIET or CAUGHT to OFF when raw detection is disabled.

Top module: `gpio_irq_bank`

## Requirements
- R1: With detect field 0 the pin is level sensed. Polarity 1 sets status while the synchronized input is 1, and polarity 0 sets it while the input is 0. The status is sticky.
- R2: In the wide variant (DETECT_W=2), detect 1 catches rising edges, 2 catches falling edges and 3 catches both. Polarity has no effect in these modes.
- R3: In the narrow variant (DETECT_W=1), only the detect bit at position 2 is stored, and bit 3 reads back as 0. Detect 1 with polarity 1 catches rising edges, and with polarity 0 it catches falling edges.
- R4: A pin change is visible in the I/O register after 2 rising clock edges, and in the status after 3.
- R5: Status stays set until acknowledged. Writing the status register with bit 0 equal to ACK_HIGH[pin] clears it, and writing the opposite value has no effect.
- R6: When a hit and a clear fall in the same cycle, the status ends up set.
- R7: A configuration write that changes the enable bit (bit 0) from 0 to 1 clears a stale status.
- R8: irq_out[t] is 1 exactly when some pin has status set, enable set and a target field (bits 7:5) equal to t. A disabled pin never drives a line.
- R9: With raw enable (bit 1) at 0, the status is held at 0 and nothing is detected. Turning raw enable back on does not by itself set the status.
- R10: After reset, every configuration register reads 0x16 (enable 0, raw enable 1, detect 1, polarity 1, target 0), and all status bits and irq_out are 0.
- R11: The register address is {pin, sel}. sel 0 is the configuration register (bit 0 enable, bit 1 raw enable, bits 3:2 detect, bit 4 polarity, bits 7:5 target). sel 1 is status in bit 0. sel 2 is the read-only synchronized input in bit 0, and writes to it are ignored. sel 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address {pin, sel} |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| irq_out | output | 8 | One interrupt line per destination |

## Verification
The embedded properties check on every cycle the following behaviours:
- The synchronizer delay.
- That a hit always wins over a clear.
- That status stays sticky without a write.
- That raw disable forces status low, and that leaving ST_OFF never sets status.
- That unmasking clears status.
- That no interrupt line rises without an enabled, pending pin.

The bench covers what needs whole scenarios:
- A sweep over every detect code, polarity and input transition on both variants, with expected status and routed line computed arithmetically.
- The acknowledge polarity per pin, routing to several targets and address decoding.
- The exact edge on which a pin change appears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int TGT_W   = 3;
    localparam int NUM_TGT = 1 << TGT_W;
    localparam int REG_W   = 8;

    typedef struct packed {
        logic [TGT_W-1:0] target;
        logic             pol;
        logic [1:0]       det;
        logic             raw_en;
        logic             en;
    } irq_cfg_t;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_QUIET  = 2'd1,
        ST_CAUGHT = 2'd2
    } pin_state_e;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_STS  = 2'd1,
        SEL_IO   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam irq_cfg_t CFG_RESET = '{target: '0, pol: 1'b1, det: 2'b01,
                                       raw_en: 1'b1, en: 1'b0};

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] prv
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic s1, s2, s3;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin_async[p];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign lvl[p] = s2;
        assign prv[p] = s3;

        // R4: a rise at the synchronizer output reflects the pin two edges back
        a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lvl[p]) |-> $past(pin_async[p], 2));
    end

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
#(
    parameter int   DETECT_W = 2,
    parameter logic ACK_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             prv,
    input  logic             cfg_wr,
    input  logic             sts_wr,
    input  logic [REG_W-1:0] wdata,
    output irq_cfg_t         cfg_q,
    output logic             status
);

    irq_cfg_t   wcfg;
    pin_state_e state, state_nx;
    logic       rise, fall, hit;
    logic       ack_clr, unmask_clr, clr;

    // configuration register; narrow variant keeps only detect bit 0
    always_comb begin
        wcfg = irq_cfg_t'(wdata);
        if (DETECT_W == 1) wcfg.det[1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= wcfg;
    end

    assign rise = lvl & ~prv;
    assign fall = ~lvl & prv;

    if (DETECT_W == 2) begin : g_wide
        always_comb begin
            unique case (cfg_q.det)
                2'd0:    hit = (lvl == cfg_q.pol);
                2'd1:    hit = rise;
                2'd2:    hit = fall;
                default: hit = rise | fall;
            endcase
        end
    end else begin : g_narrow
        assign hit = (cfg_q.det != 2'd0) ? (cfg_q.pol ? rise : fall)
                                         : (lvl == cfg_q.pol);
    end

    assign ack_clr    = sts_wr && (wdata[0] == ACK_HIGH);
    assign unmask_clr = cfg_wr && wdata[0] && !cfg_q.en;
    assign clr        = ack_clr || unmask_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (cfg_q.raw_en) state_nx = ST_QUIET;
            end
            ST_QUIET: begin
                if (!cfg_q.raw_en) state_nx = ST_OFF;
                else if (hit)      state_nx = ST_CAUGHT;
            end
            ST_CAUGHT: begin
                if (!cfg_q.raw_en) state_nx = ST_OFF;
                else if (hit)      state_nx = ST_CAUGHT;
                else if (clr)      state_nx = ST_QUIET;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        status = (state == ST_CAUGHT);
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && cfg_q.raw_en && hit) |=> status);

    a_r9_raw_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.raw_en |=> !status);

    a_r9_no_false_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> !status);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && cfg_q.raw_en && !sts_wr && !cfg_wr) |=> status);

    a_r7_unmask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status && cfg_q.raw_en && !hit && cfg_wr && wdata[0] && !cfg_q.en) |=> !status);

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic [NPINS-1:0]            status,
    input  logic [NPINS-1:0]            en,
    input  logic [NPINS-1:0][TGT_W-1:0] target,
    output logic [NUM_TGT-1:0]          irq
);

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        logic any;
        always_comb begin
            any = 1'b0;
            for (int p = 0; p < NPINS; p++) begin
                if (status[p] && en[p] && target[p] == TGT_W'(t)) any = 1'b1;
            end
        end
        assign irq[t] = any;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int               NPINS    = 4,
    parameter int               DETECT_W = 2,
    parameter logic [NPINS-1:0] ACK_HIGH = '1,
    localparam int              PW       = (NPINS > 1) ? $clog2(NPINS) : 1,
    localparam int              AW       = PW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_in,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [NUM_TGT-1:0] irq_out
);

    logic [PW-1:0]   pin_sel;
    reg_sel_e        sel;
    logic            pin_ok;
    logic [NPINS-1:0] lvl, prv;
    logic [NPINS-1:0] sts_vec, en_vec;
    logic [NPINS-1:0][TGT_W-1:0] tgt_vec;
    irq_cfg_t        cfg_arr [NPINS];

    assign pin_sel = addr[AW-1:2];
    assign sel     = reg_sel_e'(addr[1:0]);
    assign pin_ok  = int'(pin_sel) < NPINS;

    gpio_irq_sync #(.NPINS(NPINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .lvl       (lvl),
        .prv       (prv)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic hit_me, cfg_wr, sts_wr;
        assign hit_me = wr_en && pin_ok && (pin_sel == PW'(p));
        assign cfg_wr = hit_me && (sel == SEL_CFG);
        assign sts_wr = hit_me && (sel == SEL_STS);

        gpio_irq_pin #(.DETECT_W(DETECT_W), .ACK_HIGH(ACK_HIGH[p])) u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (lvl[p]),
            .prv    (prv[p]),
            .cfg_wr (cfg_wr),
            .sts_wr (sts_wr),
            .wdata  (wdata),
            .cfg_q  (cfg_arr[p]),
            .status (sts_vec[p])
        );

        assign en_vec[p]  = cfg_arr[p].en;
        assign tgt_vec[p] = cfg_arr[p].target;
    end

    gpio_irq_route #(.NPINS(NPINS)) u_route (
        .status (sts_vec),
        .en     (en_vec),
        .target (tgt_vec),
        .irq    (irq_out)
    );

    always_comb begin
        rdata = '0;
        if (pin_ok) begin
            unique case (sel)
                SEL_CFG:  rdata = cfg_arr[pin_sel];
                SEL_STS:  rdata = {{(REG_W-1){1'b0}}, sts_vec[pin_sel]};
                SEL_IO:   rdata = {{(REG_W-1){1'b0}}, lvl[pin_sel]};
                default:  rdata = '0;
            endcase
        end
    end

    a_r8_no_ungated_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> (|(sts_vec & en_vec)));

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_a, rdata_b;
    logic [7:0] irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam int CFG = 0, STS = 1, IOR = 2, NON = 3;

    always #4 clk = ~clk;

    gpio_irq_bank #(.NPINS(2), .DETECT_W(2), .ACK_HIGH(2'b01)) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_a), .irq_out(irq_a));

    gpio_irq_bank #(.NPINS(2), .DETECT_W(1), .ACK_HIGH(2'b01)) u_gpio_irq_bank_w1 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_b), .irq_out(irq_b));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int p, int s, int v);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = {p[0], s[1:0]};
        wdata = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int p, int s, output int va, output int vb);
        addr = {p[0], s[1:0]};
        #1;
        va = int'(rdata_a);
        vb = int'(rdata_b);
    endtask

    function automatic int cfgv(int en, int raw, int det, int pol, int tgt);
        return (tgt % 8) * 32 + (pol % 2) * 16 + (det % 4) * 4 + (raw % 2) * 2 + (en % 2);
    endfunction

    function automatic int exp_wide(int d, int pol, int a, int b);
        case (d)
            0: return ((a == pol) || (b == pol)) ? 1 : 0;
            1: return (a == 0 && b == 1) ? 1 : 0;
            2: return (a == 1 && b == 0) ? 1 : 0;
            default: return (a != b) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_narrow(int d, int pol, int a, int b);
        if ((d % 2) == 0) return ((a == pol) || (b == pol)) ? 1 : 0;
        if (pol == 1) return (a == 0 && b == 1) ? 1 : 0;
        return (a == 1 && b == 0) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int va, vb;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10 reset state
        for (int p = 0; p < 2; p++) begin
            rd(p, CFG, va, vb);
            chk("R10 cfg wide", va, 22);
            chk("R10 cfg narrow", vb, 22);
            rd(p, STS, va, vb);
            chk("R10 status wide", va, 0);
            chk("R10 status narrow", vb, 0);
        end
        chk("R10 irq wide", int'(irq_a), 0);
        chk("R10 irq narrow", int'(irq_b), 0);

        // R1 R2 R3 R7 R8 sweep over pins, detect codes, polarity, transitions
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 4; d++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    for (int a = 0; a < 2; a++) begin
                        for (int b = 0; b < 2; b++) begin
                            pin_in[p] = a[0];
                            idle(4);
                            wr(p, CFG, cfgv(0, 1, d, pol, 4));
                            rd(p, CFG, va, vb);
                            chk("R3 cfg readback wide", va, cfgv(0, 1, d, pol, 4));
                            chk("R3 cfg readback narrow", vb, cfgv(0, 1, d % 2, pol, 4));
                            idle(2);
                            wr(p, CFG, cfgv(1, 1, d, pol, 4));
                            idle(3);
                            rd(p, STS, va, vb);
                            chk("R1/R7 status before move wide", va, (d == 0 && a == pol) ? 1 : 0);
                            chk("R1/R7 status before move narrow", vb, ((d % 2) == 0 && a == pol) ? 1 : 0);
                            pin_in[p] = b[0];
                            idle(4);
                            rd(p, STS, va, vb);
                            chk("R2 status after move wide", va, exp_wide(d, pol, a, b));
                            chk("R3 status after move narrow", vb, exp_narrow(d, pol, a, b));
                            chk("R8 routed irq wide", int'(irq_a), exp_wide(d, pol, a, b) * 16);
                            chk("R8 routed irq narrow", int'(irq_b), exp_narrow(d, pol, a, b) * 16);
                        end
                    end
                end
            end
            wr(p, CFG, cfgv(0, 1, 1, 1, 0));
            pin_in[p] = 1'b0;
            idle(4);
        end

        // R4 latency
        wr(0, CFG, cfgv(1, 1, 1, 1, 0));
        idle(4);
        pin_in[0] = 1'b1;
        @(negedge clk);
        rd(0, IOR, va, vb); chk("R4 io after 1 edge", va, 0);
        rd(0, STS, va, vb); chk("R4 status after 1 edge", va, 0);
        @(negedge clk);
        rd(0, IOR, va, vb); chk("R4 io after 2 edges", va, 1);
        rd(0, STS, va, vb); chk("R4 status after 2 edges", va, 0);
        @(negedge clk);
        rd(0, STS, va, vb); chk("R4 status after 3 edges wide", va, 1);
        chk("R4 status after 3 edges narrow", vb, 1);
        chk("R8 irq target 0", int'(irq_a), 1);

        // R5 acknowledge polarity
        wr(0, STS, 0);
        rd(0, STS, va, vb); chk("R5 pin0 write-0 ignored", va, 1);
        wr(0, STS, 1);
        rd(0, STS, va, vb); chk("R5 pin0 write-1 clears wide", va, 0);
        chk("R5 pin0 write-1 clears narrow", vb, 0);
        wr(1, CFG, cfgv(1, 1, 1, 1, 1));
        idle(2);
        pin_in[1] = 1'b1;
        idle(4);
        rd(1, STS, va, vb); chk("R5 pin1 caught", va, 1);
        chk("R8 irq target 1", int'(irq_a), 2);
        wr(1, STS, 1);
        rd(1, STS, va, vb); chk("R5 pin1 write-1 ignored", vb, 1);
        wr(1, STS, 0);
        rd(1, STS, va, vb); chk("R5 pin1 write-0 clears wide", va, 0);
        chk("R5 pin1 write-0 clears narrow", vb, 0);

        // R8 routing and gating
        pin_in = 2'b00;
        idle(4);
        wr(0, CFG, cfgv(1, 1, 1, 1, 3));
        wr(1, CFG, cfgv(1, 1, 1, 1, 3));
        pin_in[1] = 1'b1;
        idle(4);
        chk("R8 one pin on target 3", int'(irq_a), 8);
        pin_in[0] = 1'b1;
        idle(4);
        chk("R8 two pins on target 3", int'(irq_b), 8);
        wr(0, CFG, cfgv(1, 1, 1, 1, 5));
        chk("R8 split targets 3 and 5", int'(irq_a), 40);
        wr(0, CFG, cfgv(0, 1, 1, 1, 5));
        chk("R8 disabled pin gated", int'(irq_a), 8);
        rd(0, STS, va, vb); chk("R8 gated status kept", va, 1);
        wr(1, CFG, cfgv(0, 1, 1, 1, 0));

        // R7 unmask clears stale status
        wr(0, CFG, cfgv(1, 1, 1, 1, 5));
        rd(0, STS, va, vb);
        chk("R7 unmask clears wide", va, 0);
        chk("R7 unmask clears narrow", vb, 0);
        chk("R7 irq after unmask", int'(irq_a), 0);

        // R6 set wins over same-cycle acknowledge (pin0 high, level high)
        wr(0, CFG, cfgv(1, 1, 0, 1, 5));
        idle(2);
        rd(0, STS, va, vb); chk("R1 level high caught", va, 1);
        wr(0, STS, 1);
        rd(0, STS, va, vb);
        chk("R6 set wins wide", va, 1);
        chk("R6 set wins narrow", vb, 1);
        pin_in[0] = 1'b0;
        idle(4);
        rd(0, STS, va, vb); chk("R1 level sticky", va, 1);
        wr(0, STS, 1);
        rd(0, STS, va, vb); chk("R5 ack after level gone", va, 0);

        // R9 raw enable
        wr(0, CFG, cfgv(1, 1, 1, 1, 5));
        pin_in[0] = 1'b1;
        idle(4);
        rd(0, STS, va, vb); chk("R9 caught before raw off", va, 1);
        wr(0, CFG, cfgv(1, 0, 1, 1, 5));
        idle(1);
        rd(0, STS, va, vb);
        chk("R9 raw off clears wide", va, 0);
        chk("R9 raw off clears narrow", vb, 0);
        chk("R9 raw off irq", int'(irq_a), 0);
        pin_in[0] = 1'b0; idle(4);
        pin_in[0] = 1'b1; idle(4);
        rd(0, STS, va, vb); chk("R9 no detect while off", va, 0);
        wr(0, CFG, cfgv(1, 1, 1, 1, 5));
        idle(4);
        rd(0, STS, va, vb);
        chk("R9 rearm no false status wide", va, 0);
        chk("R9 rearm no false status narrow", vb, 0);
        pin_in[0] = 1'b0; idle(4);
        pin_in[0] = 1'b1; idle(4);
        rd(0, STS, va, vb); chk("R9 detect after rearm", va, 1);

        // R11 address decode
        rd(0, NON, va, vb); chk("R11 sel 3 reads 0", va, 0);
        wr(0, IOR, 255);
        rd(0, IOR, va, vb); chk("R11 io follows pin", va, 1);
        pin_in[0] = 1'b0; idle(3);
        rd(0, IOR, va, vb); chk("R11 io write ignored", va, 0);
        rd(0, CFG, va, vb); chk("R11 cfg unchanged by io write", va, cfgv(1, 1, 1, 1, 5));

        done = 1;
        summary();
        $finish;
    end

endmodule